// File: doc/BRIEF.md
# PLL Reconfiguration Completion Tracker

This block sits beside a PLL's serial scan interface and follows the handshake between a reconfiguration controller and the PLL. An update request strobe starts a reconfiguration. The block then raises a busy flag. It watches the PLL's scan-done signal until that signal shows the reconfiguration has finished. It then drops busy and issues a single-cycle done pulse. Scan data read back from the PLL is only meaningful while busy is high.

A parameter selects how scan-done is read. In the level convention, scan-done is normally high. It falls after an update is requested, and its return to high marks completion. In the pulse convention, scan-done is normally low and is high for exactly one cycle at completion. The block also carries the PLL reset request straight through to the PLL reset output. This block is the only path by which the PLL can be reset. If nothing drives the request, the system ties it to 0.

Top module: `pll_cfg_done_tracker`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `busy_o` and `done_o` are 0.
- R2: An `upd_req_i` high on a clock edge while `busy_o` is 0 makes `busy_o` 1 from that edge on.
- R3: An `upd_req_i` high on an edge while `busy_o` is 1 is ignored. This includes the edge on which completion is detected. It neither extends busy nor causes a second done pulse.
- R4: With `CONV` = `SD_LEVEL` (encoding 0), a scan-done that is high while busy, before it has been seen low during that busy period, does not complete the reconfiguration.
- R5: With `CONV` = `SD_LEVEL`, the first edge on which `scan_done_i` is high, after it was sampled low while busy, is the completion edge. After that edge, `busy_o` is 0 and `done_o` is 1.
- R6: With `CONV` = `SD_PULSE` (encoding 1), any edge on which `scan_done_i` is high while `busy_o` is 1 is the completion edge. After it, `busy_o` is 0 and `done_o` is 1.
- R7: A scan-done level or pulse while `busy_o` is 0 has no effect: `done_o` stays 0 and `busy_o` stays 0.
- R8: `done_o` is high for exactly one cycle per completion. It is never high while `busy_o` is 1.
- R9: `pll_rst_o` equals `pll_rst_req_i` at all times, with no clock delay and independent of `rst_n` and of busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the tracker state |
| upd_req_i | input | 1 | Single-cycle request to start a reconfiguration update |
| scan_done_i | input | 1 | Scan-done indication from the PLL |
| pll_rst_req_i | input | 1 | PLL reset request (tied to 0 when unused) |
| busy_o | output | 1 | Reconfiguration in progress; read-back scan data valid |
| done_o | output | 1 | One-cycle pulse after completion is detected |
| pll_rst_o | output | 1 | Reset to the PLL, follows `pll_rst_req_i` |

## Verification
The properties assume that the PLL follows its own convention. In level mode, scan-done drops only after an update was accepted and rises once. In pulse mode, scan-done is high for single cycles only. The properties also assume that the update request is a one-cycle strobe. The stimulus drives the inputs only on falling edges and follows these rules. The one exception is idle-time scan-done activity and requests during busy, which the bench injects on purpose, since the block must tolerate both.

// File: rtl/pll_trk_pkg.sv
package pll_trk_pkg;

    // Scan-done convention: level drops on update / rises at completion,
    // or a single-cycle completion pulse.
    typedef enum logic {
        SD_LEVEL = 1'b0,
        SD_PULSE = 1'b1
    } sd_conv_e;

    typedef struct packed {
        logic busy;
        logic done;
    } trk_state_t;

    typedef struct packed {
        logic seen_low;
    } det_state_t;

endpackage

// File: rtl/pll_trk_detect.sv
module pll_trk_detect #(
    parameter pll_trk_pkg::sd_conv_e CONV = pll_trk_pkg::SD_LEVEL
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic scan_done_i,
    output logic complete_o
);
    import pll_trk_pkg::*;

    generate
        if (CONV == SD_LEVEL) begin : g_level
            det_state_t st_d, st_q;

            // Remember a low scan-done inside the current busy period.
            always_comb begin
                st_d = st_q;
                if (!busy_i) begin
                    st_d.seen_low = 1'b0;
                end else if (!scan_done_i) begin
                    st_d.seen_low = 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign complete_o = busy_i & st_q.seen_low & scan_done_i;
        end else begin : g_pulse
            logic unused_pulse_inputs;
            assign unused_pulse_inputs = clk ^ rst_n;
            assign complete_o = busy_i & scan_done_i;
        end
    endgenerate

endmodule

// File: rtl/pll_trk_ctrl.sv
module pll_trk_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_req_i,
    input  logic complete_i,
    output logic busy_o,
    output logic done_o
);
    import pll_trk_pkg::*;

    trk_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            // Requests while busy are dropped.
            if (complete_i) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (upd_req_i) begin
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;

endmodule

// File: rtl/pll_trk_rst_pass.sv
module pll_trk_rst_pass (
    input  logic req_i,
    output logic rst_o
);
    // The PLL has no other reset source: straight wire, no retiming.
    assign rst_o = req_i;
endmodule

// File: rtl/pll_cfg_done_tracker.sv
module pll_cfg_done_tracker #(
    parameter pll_trk_pkg::sd_conv_e CONV = pll_trk_pkg::SD_LEVEL
) (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_req_i,
    input  logic scan_done_i,
    input  logic pll_rst_req_i,
    output logic busy_o,
    output logic done_o,
    output logic pll_rst_o
);
    logic busy_w;
    logic complete_w;

    pll_trk_detect #(.CONV(CONV)) detect_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy_i      (busy_w),
        .scan_done_i (scan_done_i),
        .complete_o  (complete_w)
    );

    pll_trk_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_req_i  (upd_req_i),
        .complete_i (complete_w),
        .busy_o     (busy_w),
        .done_o     (done_o)
    );

    pll_trk_rst_pass rst_pass_i (
        .req_i (pll_rst_req_i),
        .rst_o (pll_rst_o)
    );

    assign busy_o = busy_w;

endmodule

// File: rtl/pll_trk_chk.sv
module pll_trk_chk #(
    parameter pll_trk_pkg::sd_conv_e CONV = pll_trk_pkg::SD_LEVEL
) (
    input logic clk,
    input logic rst_n,
    input logic upd_req_i,
    input logic scan_done_i,
    input logic pll_rst_req_i,
    input logic busy_o,
    input logic done_o,
    input logic pll_rst_o
);
    import pll_trk_pkg::*;

    p_busy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && upd_req_i) |=> busy_o);

    p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && upd_req_i && !scan_done_i) |=> (busy_o && !done_o));

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> !done_o);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_rst_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst_o == pll_rst_req_i);

    generate
        if (CONV == SD_LEVEL) begin : g_level
            p_need_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(busy_o) && scan_done_i) |=> busy_o);

            p_done_on_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
                done_o |-> $past(scan_done_i));
        end else begin : g_pulse
            p_pulse_cmpl_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (busy_o && scan_done_i) |=> (done_o && !busy_o));
        end
    endgenerate

endmodule

bind pll_cfg_done_tracker pll_trk_chk #(.CONV(CONV)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .upd_req_i     (upd_req_i),
    .scan_done_i   (scan_done_i),
    .pll_rst_req_i (pll_rst_req_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .pll_rst_o     (pll_rst_o)
);

// File: tb/pll_cfg_done_tracker_tb_top.sv
module pll_cfg_done_tracker_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic upd_l, upd_p, sd_l, sd_p, prq;
    logic busy_l, done_l, rst_l;
    logic busy_p, done_p, rst_p;

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    int exp_l[$];
    int exp_p[$];
    int e_l, e_p;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    pll_cfg_done_tracker #(.CONV(pll_trk_pkg::SD_LEVEL)) dut_i (
        .clk(clk), .rst_n(rst_n), .upd_req_i(upd_l), .scan_done_i(sd_l),
        .pll_rst_req_i(prq), .busy_o(busy_l), .done_o(done_l), .pll_rst_o(rst_l)
    );

    pll_cfg_done_tracker #(.CONV(pll_trk_pkg::SD_PULSE)) dut_p_i (
        .clk(clk), .rst_n(rst_n), .upd_req_i(upd_p), .scan_done_i(sd_p),
        .pll_rst_req_i(prq), .busy_o(busy_p), .done_o(done_p), .pll_rst_o(rst_p)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic nxt(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    // Scoreboard monitors: each done pulse must match the next expected cycle.
    always @(negedge clk) begin
        if (rst_n && done_l) begin
            if (exp_l.size() == 0) begin
                chk(1'b0, "R8 level: unexpected done", cyc, -1);
            end else begin
                e_l = exp_l.pop_front();
                chk(e_l == cyc, "R5 level: done cycle", cyc, e_l);
            end
        end
        if (rst_n && done_p) begin
            if (exp_p.size() == 0) begin
                chk(1'b0, "R8 pulse: unexpected done", cyc, -1);
            end else begin
                e_p = exp_p.pop_front();
                chk(e_p == cyc, "R6 pulse: done cycle", cyc, e_p);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; upd_l = 1'b0; upd_p = 1'b0;
        sd_l = 1'b1; sd_p = 1'b0; prq = 1'b1;
        nxt(3);
        chk(busy_l == 1'b0, "R1 level busy in reset", busy_l, 0);
        chk(done_l == 1'b0, "R1 level done in reset", done_l, 0);
        chk(busy_p == 1'b0, "R1 pulse busy in reset", busy_p, 0);
        chk(rst_l == 1'b1 && rst_p == 1'b1, "R9 pass-through in reset", rst_l, 1);
        prq = 1'b0; #1;
        chk(rst_l == 1'b0 && rst_p == 1'b0, "R9 pass-through low", rst_l, 0);
        rst_n = 1'b1;
        nxt(1);
        chk(busy_l == 1'b0 && done_l == 1'b0, "R1 after reset", busy_l, 0);

        // Level: normal drop then rise
        upd_l = 1'b1; nxt(1); upd_l = 1'b0;
        chk(busy_l == 1'b1, "R2 level busy after strobe", busy_l, 1);
        sd_l = 1'b0; nxt(3);
        chk(busy_l == 1'b1, "R5 level busy while low", busy_l, 1);
        prq = 1'b1; #1;
        chk(rst_l == 1'b1, "R9 pass-through while busy", rst_l, 1);
        sd_l = 1'b1; exp_l.push_back(cyc + 1); nxt(1);
        chk(busy_l == 1'b0, "R5 level busy cleared", busy_l, 0);
        chk(done_l == 1'b1, "R5 level done pulse", done_l, 1);
        nxt(1);
        chk(done_l == 1'b0, "R8 level done one cycle", done_l, 0);
        prq = 1'b0; #1;
        chk(rst_l == 1'b0, "R9 pass-through release", rst_l, 0);

        // Level: high while busy without a prior low must not complete
        upd_l = 1'b1; nxt(1); upd_l = 1'b0; nxt(4);
        chk(busy_l == 1'b1, "R4 level high without low", busy_l, 1);
        sd_l = 1'b0; nxt(1);
        sd_l = 1'b1; exp_l.push_back(cyc + 1); nxt(1);
        chk(busy_l == 1'b0, "R4 level completes after low", busy_l, 0);
        nxt(1);

        // Level: strobes while busy and on completion edge are ignored
        upd_l = 1'b1; nxt(1); upd_l = 1'b0; sd_l = 1'b0; nxt(1);
        upd_l = 1'b1; nxt(1); upd_l = 1'b0;
        chk(busy_l == 1'b1, "R3 level busy unchanged", busy_l, 1);
        nxt(1);
        sd_l = 1'b1; upd_l = 1'b1; exp_l.push_back(cyc + 1); nxt(1);
        upd_l = 1'b0;
        chk(busy_l == 1'b0, "R3 level strobe at completion ignored", busy_l, 0);
        nxt(3);
        chk(busy_l == 1'b0 && done_l == 1'b0, "R3 level no restart", busy_l, 0);

        // Pulse: idle pulse ignored
        sd_p = 1'b1; nxt(1); sd_p = 1'b0;
        chk(busy_p == 1'b0, "R7 pulse idle busy", busy_p, 0);
        chk(done_p == 1'b0, "R7 pulse idle done", done_p, 0);
        nxt(1);

        // Pulse: completion after a wait
        upd_p = 1'b1; nxt(1); upd_p = 1'b0;
        chk(busy_p == 1'b1, "R2 pulse busy after strobe", busy_p, 1);
        nxt(2);
        sd_p = 1'b1; exp_p.push_back(cyc + 1); nxt(1); sd_p = 1'b0;
        chk(busy_p == 1'b0, "R6 pulse busy cleared", busy_p, 0);
        chk(done_p == 1'b1, "R6 pulse done", done_p, 1);
        nxt(1);
        chk(done_p == 1'b0, "R8 pulse done one cycle", done_p, 0);

        // Pulse: completion on first busy cycle
        upd_p = 1'b1; nxt(1); upd_p = 1'b0;
        sd_p = 1'b1; exp_p.push_back(cyc + 1); nxt(1); sd_p = 1'b0;
        chk(busy_p == 1'b0, "R6 pulse immediate completion", busy_p, 0);

        // Pulse: strobe during busy ignored
        nxt(1);
        upd_p = 1'b1; nxt(1); upd_p = 1'b0; nxt(1);
        upd_p = 1'b1; nxt(1); upd_p = 1'b0;
        chk(busy_p == 1'b1, "R3 pulse busy unchanged", busy_p, 1);
        sd_p = 1'b1; exp_p.push_back(cyc + 1); nxt(1); sd_p = 1'b0;
        nxt(2);
        chk(busy_p == 1'b0, "R3 pulse no restart", busy_p, 0);

        nxt(2);
        chk(exp_l.size() == 0, "R5 level pending dones", exp_l.size(), 0);
        chk(exp_p.size() == 0, "R6 pulse pending dones", exp_p.size(), 0);
        summary();
        $finish;
    end

endmodule